// File: doc/BRIEF.md
# Coprocessor Transfer Address Generator

This block works out the memory address and the base-register update for one coprocessor load or store. Each request carries a 32-bit base value and the index of the register it came from. It also carries an 8-bit immediate and five control bits. The scale bit multiplies the immediate by four. The mode bit picks pre- or post-indexing. The direction bit chooses add or subtract. The update bit asks for the base to be written back. The result leaves the block as a memory address, a writeback value, a writeback enable and a fault flag. The fault flag marks an update aimed at the program-counter index, which the block refuses.

Requests arrive on a valid/ready input channel. Results leave on a valid/ready output channel, through one register stage. The block accepts a request on any rising edge where `req_valid` and `req_ready` are both high. The result is presented on the following cycle. While `rsp_valid` is high and `rsp_ready` is low, the result and `rsp_valid` hold steady and `req_ready` stays low. When the result is taken, a new request can be accepted in that same cycle, so the block sustains one request per cycle.

Top module: `cp_agen`

## Requirements
- R1: The offset equals the 8-bit immediate times four when `req_scale` is 1, and the immediate unchanged when `req_scale` is 0 (for example, 255 scaled gives 1020).
- R2: With `req_pre` = 1, `rsp_addr` is the base plus the offset when `req_up` = 1, and the base minus the offset when `req_up` = 0. The arithmetic is modulo 2^32 and there is no overflow indication.
- R3: With `req_pre` = 0, `rsp_addr` equals the base unchanged.
- R4: In both modes, `rsp_wb_data` is the base plus or minus the offset, with the direction chosen by `req_up`. The arithmetic is modulo 2^32.
- R5: `rsp_wb_en` is 1 exactly when `req_wb` = 1 and `req_idx` is not 15. A post-indexed request without update therefore gives no writeback.
- R6: `rsp_fault` is 1 exactly when `req_wb` = 1 and `req_idx` = 15. A faulting result never has `rsp_wb_en` set.
- R7: An accepted request appears on the output with `rsp_valid` = 1 on the next cycle. While `rsp_ready` is 0, the output holds every field and `req_ready` is 0. Once the result is taken and no new request is accepted, `rsp_valid` falls.
- R8: After reset, `rsp_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_base | input | 32 | Base register value |
| req_idx | input | 4 | Base register index |
| req_imm | input | 8 | Immediate offset |
| req_scale | input | 1 | 1: immediate times four |
| req_pre | input | 1 | 1: pre-indexed, 0: post-indexed |
| req_up | input | 1 | 1: add offset, 0: subtract |
| req_wb | input | 1 | Base update requested |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes result |
| rsp_addr | output | 32 | Memory address |
| rsp_wb_data | output | 32 | Base writeback value |
| rsp_wb_en | output | 1 | Writeback allowed |
| rsp_fault | output | 1 | Refused update to program-counter index |

## Verification
The bench checks wrap-around at both ends of the address space: subtracting from a small base, and adding to 0xFFFFFFFF. A design that widened the sum or saturated it would give a wrong address there. Index 15 is driven both with and without the update bit. A design that keyed the fault on the index alone would flag harmless reads, and one that still raised the enable would corrupt the program counter. Post-indexed requests with a non-zero offset catch any design that passes the adjusted value to memory. The largest scaled immediate exposes a scale shift that was dropped or applied to the wrong width. Randomly held-off `rsp_ready` catches outputs that change, or requests that are accepted, while a result is still waiting.

// File: rtl/cp_agen_pkg.sv
package cp_agen_pkg;
  typedef enum logic { MODE_POST = 1'b0, MODE_PRE = 1'b1 } agen_mode_e;
  typedef enum logic { DIR_SUB = 1'b0, DIR_ADD = 1'b1 } agen_dir_e;
endpackage

// File: rtl/agen_offset.sv
module agen_offset #(
  parameter int IMM_W    = 8,
  parameter int ADDR_W   = 32,
  parameter int SCALE_SH = 2
) (
  input  logic [IMM_W-1:0]  imm,
  input  logic              scale,
  output logic [ADDR_W-1:0] off
);
  localparam int PAD_W = ADDR_W - IMM_W;
  logic [ADDR_W-1:0] wide;
  assign wide = {{PAD_W{1'b0}}, imm};
  generate
    if (SCALE_SH > 0) begin : g_shift
      assign off = scale ? (wide << SCALE_SH) : wide;
    end else begin : g_flat
      assign off = wide;
    end
  endgenerate
endmodule

// File: rtl/agen_sum.sv
module agen_sum
  import cp_agen_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] off,
  input  agen_dir_e         dir,
  input  agen_mode_e        mode,
  output logic [ADDR_W-1:0] adj,
  output logic [ADDR_W-1:0] addr
);
  always_comb begin
    adj  = (dir == DIR_ADD) ? (base + off) : (base - off);
    addr = (mode == MODE_PRE) ? adj : base;
  end
endmodule

// File: rtl/agen_wb_guard.sv
module agen_wb_guard #(
  parameter int IDX_W  = 4,
  parameter int PC_IDX = 15
) (
  input  logic [IDX_W-1:0] idx,
  input  logic             wb,
  output logic             wb_en,
  output logic             fault
);
  localparam logic [IDX_W-1:0] PC_CODE = IDX_W'(PC_IDX);
  logic is_pc;
  assign is_pc = (idx == PC_CODE);
  assign wb_en = wb & ~is_pc;
  assign fault = wb & is_pc;
endmodule

// File: rtl/cp_agen.sv
module cp_agen
  import cp_agen_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int IDX_W    = 4,
  parameter int IMM_W    = 8,
  parameter int SCALE_SH = 2,
  parameter int PC_IDX   = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic [IMM_W-1:0]  req_imm,
  input  logic              req_scale,
  input  logic              req_pre,
  input  logic              req_up,
  input  logic              req_wb,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [ADDR_W-1:0] rsp_wb_data,
  output logic              rsp_wb_en,
  output logic              rsp_fault
);
  logic [ADDR_W-1:0] off_c, adj_c, addr_c;
  logic              wb_en_c, fault_c;
  logic              take;

  agen_offset #(.IMM_W(IMM_W), .ADDR_W(ADDR_W), .SCALE_SH(SCALE_SH)) u_off (
    .imm(req_imm), .scale(req_scale), .off(off_c)
  );

  agen_sum #(.ADDR_W(ADDR_W)) u_sum (
    .base(req_base), .off(off_c),
    .dir(agen_dir_e'(req_up)), .mode(agen_mode_e'(req_pre)),
    .adj(adj_c), .addr(addr_c)
  );

  agen_wb_guard #(.IDX_W(IDX_W), .PC_IDX(PC_IDX)) u_guard (
    .idx(req_idx), .wb(req_wb), .wb_en(wb_en_c), .fault(fault_c)
  );

  assign req_ready = ~rsp_valid | rsp_ready;
  assign take      = req_valid & req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_addr    <= '0;
      rsp_wb_data <= '0;
      rsp_wb_en   <= 1'b0;
      rsp_fault   <= 1'b0;
    end else begin
      if (take) begin
        rsp_valid   <= 1'b1;
        rsp_addr    <= addr_c;
        rsp_wb_data <= adj_c;
        rsp_wb_en   <= wb_en_c;
        rsp_fault   <= fault_c;
      end else if (rsp_ready) begin
        rsp_valid   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cp_agen_chk.sv
module cp_agen_chk #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4,
  parameter int PC_IDX = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_base,
  input logic [IDX_W-1:0]  req_idx,
  input logic              req_pre,
  input logic              req_wb,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [ADDR_W-1:0] rsp_addr,
  input logic [ADDR_W-1:0] rsp_wb_data,
  input logic              rsp_wb_en,
  input logic              rsp_fault
);
  a_r7_accept_shows: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr) &&
      $stable(rsp_wb_data) && $stable(rsp_wb_en) && $stable(rsp_fault)));

  a_r7_no_take_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  a_r3_post_base: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_pre) |=> (rsp_addr == $past(req_base)));

  a_r6_pc_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_wb && req_idx == IDX_W'(PC_IDX)) |=>
      (rsp_fault && !rsp_wb_en));

  a_r5_wb_allowed: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_wb && req_idx != IDX_W'(PC_IDX)) |=>
      (rsp_wb_en && !rsp_fault));

  a_r5_no_wb_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_wb) |=> (!rsp_wb_en && !rsp_fault));

  a_r2_pre_match: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_pre) |=> (rsp_addr == rsp_wb_data));
endmodule

bind cp_agen cp_agen_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .PC_IDX(PC_IDX)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_base(req_base), .req_idx(req_idx), .req_pre(req_pre), .req_wb(req_wb),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr),
  .rsp_wb_data(rsp_wb_data), .rsp_wb_en(rsp_wb_en), .rsp_fault(rsp_fault)
);

// File: tb/cp_agen_tb_top.sv
`timescale 1ns/1ps
module cp_agen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_base = '0;
  logic [3:0]  req_idx = '0;
  logic [7:0]  req_imm = '0;
  logic        req_scale = 1'b0, req_pre = 1'b0, req_up = 1'b0, req_wb = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_addr, rsp_wb_data;
  logic        rsp_wb_en, rsp_fault;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  cp_agen dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_base(req_base), .req_idx(req_idx), .req_imm(req_imm),
    .req_scale(req_scale), .req_pre(req_pre), .req_up(req_up), .req_wb(req_wb),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr),
    .rsp_wb_data(rsp_wb_data), .rsp_wb_en(rsp_wb_en), .rsp_fault(rsp_fault)
  );

  function automatic logic [31:0] exp_off(logic [7:0] imm, logic sc);
    return sc ? {22'd0, imm, 2'b00} : {24'd0, imm};
  endfunction

  function automatic logic [31:0] exp_adj(logic [31:0] b, logic [7:0] imm, logic sc, logic up);
    return up ? b + exp_off(imm, sc) : b - exp_off(imm, sc);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run(logic [31:0] b, logic [3:0] ix, logic [7:0] imm,
                     logic sc, logic pre, logic up, logic wb, int hold);
    logic [31:0] e_adj;
    e_adj = exp_adj(b, imm, sc, up);
    @(negedge clk);
    req_base = b; req_idx = ix; req_imm = imm;
    req_scale = sc; req_pre = pre; req_up = up; req_wb = wb;
    req_valid = 1'b1; rsp_ready = 1'b0;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R7 valid after accept", 32'(rsp_valid), 32'd1);
    for (int h = 0; h < hold; h++) begin
      @(posedge clk);
      @(negedge clk);
      chk("R7 held valid", 32'(rsp_valid), 32'd1);
      chk("R7 ready low while full", 32'(req_ready), 32'd0);
    end
    chk(pre ? "R2 pre address" : "R3 post address", rsp_addr, pre ? e_adj : b);
    chk("R4 writeback data", rsp_wb_data, e_adj);
    chk("R5 writeback enable", 32'(rsp_wb_en), 32'(wb && ix != 4'd15));
    chk("R6 fault", 32'(rsp_fault), 32'(wb && ix == 4'd15));
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rsp_ready = 1'b0;
    chk("R7 valid drops after take", 32'(rsp_valid), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 reset valid", 32'(rsp_valid), 32'd0);
    chk("R8 reset ready", 32'(req_ready), 32'd1);
    rst_n = 1'b1;
    // R1 largest scaled immediate, pre add
    run(32'h0000_1000, 4'd3, 8'hFF, 1'b1, 1'b1, 1'b1, 1'b0, 0);
    // R1 unscaled
    run(32'h0000_1000, 4'd3, 8'hFF, 1'b0, 1'b1, 1'b1, 1'b0, 1);
    // R2 wrap below zero
    run(32'h0000_0002, 4'd1, 8'h01, 1'b1, 1'b1, 1'b0, 1'b1, 2);
    // R2 wrap above top
    run(32'hFFFF_FFFF, 4'd0, 8'h01, 1'b0, 1'b1, 1'b1, 1'b0, 0);
    // R3 post with writeback
    run(32'h8000_0000, 4'd7, 8'h10, 1'b1, 1'b0, 1'b0, 1'b1, 1);
    // R5 post without writeback
    run(32'h1234_5678, 4'd9, 8'h20, 1'b0, 1'b0, 1'b1, 1'b0, 0);
    // R6 program counter with and without update
    run(32'h0000_4000, 4'd15, 8'h04, 1'b0, 1'b1, 1'b1, 1'b1, 3);
    run(32'h0000_4000, 4'd15, 8'h04, 1'b0, 1'b0, 1'b1, 1'b1, 0);
    run(32'h0000_4000, 4'd15, 8'h04, 1'b1, 1'b1, 1'b0, 1'b0, 0);
    for (int n = 0; n < 300; n++) begin
      run($urandom, 4'($urandom), 8'($urandom), 1'($urandom), 1'($urandom),
          1'($urandom), 1'($urandom), int'($urandom % 3));
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule